// File: doc/BRIEF.md
# Byte-wide SPI Master Engine

This block drives a serial peripheral bus as its controller, one 8-bit word at a time. Software-side logic writes a 16-bit setup word and loads outgoing bytes into an internal transmit queue. Whenever the engine is allowed to run and a byte is waiting, it shifts that byte out most significant bit first. At the same time it shifts in the byte returned by the selected peripheral and appends that byte to an internal receive queue.

The serial clock is derived from the block clock by a divider that is a power of two. All four polarity/phase combinations are available. Four active-low select lines are taken straight from a field of the setup word. Software can therefore place either an inverted one-hot pattern or a binary peripheral number there. An automatic mode instead holds the lines at all-ones except while a byte is on the wire.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the setup word reads 16'h7C09: bit 0 (run) set, divider code 1 in bits 5:3, select field bits 13:10 all ones, bit 14 (manual select) set, and polarity and phase clear. Also after reset, sclk is low, ss_n is 4'hF, mosi is 0, busy is low and the receive queue is empty.
- R2: A byte starts only when setup bit 0 and the ctrl_en input are both high and the transmit queue is non-empty. Otherwise queued bytes stay untouched and busy stays low.
- R3: Setup bits 5:3 hold a code N, and each half period of sclk lasts 2^N block clock cycles. A code of 0 is treated as 1.
- R4: Setup bit 1 (polarity) sets the idle level of sclk. After the 16th edge of a byte, sclk is back at that level.
- R5: With setup bit 2 (phase) clear, mosi carries bit 7 before the first edge. Incoming data is captured on odd-numbered edges (1st, 3rd, ...), and mosi moves to the next bit on even-numbered edges.
- R6: With phase set, mosi moves to the next bit on odd-numbered edges, and incoming data is captured on even-numbered edges.
- R7: Bits leave and arrive MSB first. Every byte sent yields exactly one byte in the receive queue, so a mosi-to-miso loopback returns the byte that was sent.
- R8: When setup bit 14 is set, ss_n equals setup bits 13:10 unchanged, whether that field holds an inverted one-hot pattern or a binary code. When bit 14 is clear, ss_n shows the field only while busy and is 4'hF otherwise.
- R9: A write to a full transmit queue is dropped. No byte starts while the receive queue is full. A read of an empty receive queue has no effect.
- R10: busy rises on the cycle after a byte is taken from the queue and falls when its received byte is stored. Polarity, phase and divider are latched when the byte starts, so setup writes during a byte do not affect that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; while low no byte starts |
| cfg_wr | input | 1 | Setup word write strobe |
| cfg_wdata | input | 16 | Setup word to write |
| cfg_rdata | output | 16 | Current setup word |
| tx_wr | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | A byte is on the wire |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low peripheral select lines |

## Verification
The bench builds the engine with a queue depth of 4 instead of the default 128. This makes a full transmit queue, a dropped fifth write and a stall on a full receive queue reachable within a few bytes. The divider codes exercised are 0, 1, 2 and 3, so code clamping and several half-period lengths are all checked against sclk timing. Both a loopback and a pseudo-random miso stream are used, in all four modes and with setup writes landing in the middle of a byte.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_en,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        tx_wr,
  input  logic [7:0]  tx_wdata,
  output logic        tx_full,
  input  logic        rx_rd,
  output logic [7:0]  rx_rdata,
  output logic        rx_empty,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  ss_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [15:0] CFG_RST = 16'h7C09;

  logic [15:0] cfg_q;
  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;
  logic          active, sclk_q, mosi_q, l_cpol, l_cpha;
  logic [2:0]    l_div;
  logic [6:0]    cnt;
  logic [3:0]    e;
  logic [7:0]    sh, rsh;

  wire        tx_ok    = tx_wr && (tx_cnt != FULL);
  wire        rx_pop   = rx_rd && (rx_cnt != '0);
  wire        start    = !active && cfg_q[0] && ctrl_en && (tx_cnt != '0) && (rx_cnt != FULL);
  wire [2:0]  div_code = (cfg_q[5:3] == 3'd0) ? 3'd1 : cfg_q[5:3];
  wire [6:0]  half_m1  = 7'h7F >> (3'd7 - l_div);
  wire        tick     = active && (cnt == half_m1);
  wire        lead     = !e[0];
  wire        smp      = tick && (lead ^ l_cpha);
  wire        shift_ev = tick && (lead == l_cpha);
  wire        done     = tick && (e == 4'd15);
  wire [7:0]  rsh_nx   = {rsh[6:0], miso};
  wire [7:0]  rx_byte  = smp ? rsh_nx : rsh;

  assign cfg_rdata = cfg_q;
  assign tx_full   = (tx_cnt == FULL);
  assign rx_empty  = (rx_cnt == '0);
  assign rx_rdata  = rx_mem[rx_rp];
  assign busy      = active;
  assign mosi      = mosi_q;
  assign sclk      = active ? sclk_q : cfg_q[1];
  assign ss_n      = (cfg_q[14] || active) ? cfg_q[13:10] : 4'hF;

  always_ff @(posedge clk) begin
    if (tx_ok) tx_mem[tx_wp] <= tx_wdata;
    if (done)  rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      tx_wp  <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp  <= '0; rx_rp <= '0; rx_cnt <= '0;
      active <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      l_cpol <= 1'b0; l_cpha <= 1'b0; l_div <= 3'd1;
      cnt    <= '0; e <= '0; sh <= '0; rsh <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata;
      if (tx_ok)  tx_wp <= tx_wp + 1'b1;
      if (start)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (AW+1)'(tx_ok) - (AW+1)'(start);
      if (done)   rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (AW+1)'(done) - (AW+1)'(rx_pop);

      if (start) begin
        active <= 1'b1;
        sh     <= tx_mem[tx_rp];
        e      <= '0;
        cnt    <= '0;
        l_cpol <= cfg_q[1];
        l_cpha <= cfg_q[2];
        l_div  <= div_code;
        sclk_q <= cfg_q[1];
        if (!cfg_q[2]) mosi_q <= tx_mem[tx_rp][7];
      end else if (active) begin
        if (tick) begin
          cnt    <= '0;
          sclk_q <= ~sclk_q;
          e      <= e + 1'b1;
          if (smp) rsh <= rsh_nx;
          if (shift_ev) begin
            mosi_q <= l_cpha ? sh[7] : sh[6];
            sh     <= {sh[6:0], 1'b0};
          end
          if (done) active <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_LEVEL:   assert property (@(posedge clk) disable iff (!rst_n) $fell(active) |-> sclk_q == l_cpol); // R4
  AST_NO_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> rx_cnt != FULL); // R9
  AST_TX_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R9
  AST_MODE_HELD:    assert property (@(posedge clk) disable iff (!rst_n) (active && $past(active)) |-> ($stable(l_cpha) && $stable(l_cpol) && $stable(l_div))); // R10
  AST_TICK_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) active |-> cnt <= half_m1); // R3
  AST_START_GATE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(active) |-> $past(cfg_q[0] && ctrl_en)); // R2
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic ctrl_en = 0, cfg_wr = 0, tx_wr = 0, rx_rd = 0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  tx_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [7:0]  rx_rdata;
  logic tx_full, rx_empty, busy, sclk, mosi, miso;
  logic [3:0] ss_n;
  logic lb = 1;
  logic [7:0] lfsr = 8'h5B;

  always #10 clk = ~clk;
  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign miso = lb ? mosi : lfsr[0];

  spi_byte_master #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [15:0] m_cfg;
  logic m_act, m_sclk, m_mosi, m_cpol, m_cpha, m_go;
  logic [7:0] m_byte, m_rx;
  int m_c, m_half, k, txn, rxn, dv, nb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_cfg = 16'h7C09; m_act = 0; m_sclk = 0; m_mosi = 0;
      m_cpol = 0; m_cpha = 0; m_c = 0; m_half = 2; m_rx = 0; m_byte = 0;
    end else begin
      txn = txq.size(); rxn = rxq.size();
      m_go = !m_act && m_cfg[0] && ctrl_en && txn > 0 && rxn < DEPTH;
      if (rx_rd && rxn > 0) void'(rxq.pop_front());
      if (m_act) begin
        m_c++;
        if (m_c % m_half == 0) begin
          k = m_c / m_half - 1;
          m_sclk = m_cpol ^ ((k + 1) % 2 == 1);
          if (!m_cpha) begin
            if (k % 2 == 0) m_rx = {m_rx[6:0], miso};
            else begin nb = (k + 1) / 2; m_mosi = (nb > 7) ? 1'b0 : m_byte[7 - nb]; end
          end else begin
            if (k % 2 == 1) m_rx = {m_rx[6:0], miso};
            else m_mosi = m_byte[7 - k / 2];
          end
          if (k == 15) begin rxq.push_back(m_rx); m_act = 0; end
        end
      end
      if (m_go) begin
        m_byte = txq.pop_front();
        m_act = 1; m_c = 0;
        m_cpol = m_cfg[1]; m_cpha = m_cfg[2];
        dv = (m_cfg[5:3] == 0) ? 1 : int'(m_cfg[5:3]);
        m_half = 1 << dv;
        m_sclk = m_cfg[1];
        if (!m_cfg[2]) m_mosi = m_byte[7];
      end
      if (tx_wr && txn < DEPTH) txq.push_back(tx_wdata);
      if (cfg_wr) m_cfg = cfg_wdata;
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n && !finished) begin
      logic bad;
      bad = 0;
      checks++;
      if (sclk !== (m_act ? m_sclk : m_cfg[1])) begin bad = 1; $display("FAIL R3/R4 sclk act=%0b exp=%0b t=%0t", sclk, (m_act ? m_sclk : m_cfg[1]), $time); end
      if (mosi !== m_mosi) begin bad = 1; $display("FAIL R5/R6 mosi act=%0b exp=%0b t=%0t", mosi, m_mosi, $time); end
      if (ss_n !== ((m_cfg[14] || m_act) ? m_cfg[13:10] : 4'hF)) begin bad = 1; $display("FAIL R8 ss_n act=%h exp=%h t=%0t", ss_n, ((m_cfg[14] || m_act) ? m_cfg[13:10] : 4'hF), $time); end
      if (busy !== m_act) begin bad = 1; $display("FAIL R10 busy act=%0b exp=%0b t=%0t", busy, m_act, $time); end
      if (tx_full !== (txq.size() == DEPTH)) begin bad = 1; $display("FAIL R9 tx_full act=%0b exp=%0b t=%0t", tx_full, (txq.size() == DEPTH), $time); end
      if (rx_empty !== (rxq.size() == 0)) begin bad = 1; $display("FAIL R9 rx_empty act=%0b exp=%0b t=%0t", rx_empty, (rxq.size() == 0), $time); end
      if (rxq.size() > 0 && rx_rdata !== rxq[0]) begin bad = 1; $display("FAIL R7 rx_rdata act=%h exp=%h t=%0t", rx_rdata, rxq[0], $time); end
      if (cfg_rdata !== m_cfg) begin bad = 1; $display("FAIL R1 cfg act=%h exp=%h t=%0t", cfg_rdata, m_cfg, $time); end
      if (bad) errors++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  function automatic logic [15:0] mk(input bit run, input bit cpol, input bit cpha,
                                     input logic [2:0] dv, input logic [3:0] fld, input bit man);
    return {1'b0, man, fld, 4'b0000, dv, cpha, cpol, run};
  endfunction

  task automatic wcfg(input logic [15:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask
  task automatic wtx(input logic [7:0] b);
    @(negedge clk); tx_wr = 1; tx_wdata = b;
    @(negedge clk); tx_wr = 0;
  endtask
  task automatic rrx(output logic [7:0] b);
    @(negedge clk); b = rx_rdata; rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask
  task automatic wait_idle();
    int idle = 0;
    while (idle < 4) begin @(negedge clk); idle = busy ? 0 : idle + 1; end
  endtask
  task automatic count_high(output int n);
    n = 0;
    while (!busy) @(negedge clk);
    while (busy) begin if (sclk) n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 16'h7C09, "R1 cfg", cfg_rdata, 16'h7C09);
    chk(sclk == 0 && mosi == 0, "R1 sclk/mosi", {sclk, mosi}, 0);
    chk(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
    chk(!busy && rx_empty, "R1 busy/rx_empty", {busy, rx_empty}, 1);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // R2: gate by ctrl_en, then by run bit
    wtx(8'hC3);
    repeat (20) @(negedge clk);
    chk(!busy && rx_empty, "R2 ctrl_en low holds byte", {busy, rx_empty}, 1);
    wcfg(mk(0, 0, 0, 3'd1, 4'hF, 1));
    @(negedge clk); ctrl_en = 1;
    repeat (20) @(negedge clk);
    chk(!busy && rx_empty, "R2 run bit low holds byte", {busy, rx_empty}, 1);
    wcfg(mk(1, 0, 0, 3'd1, 4'hF, 1));
    wait_idle();
    rrx(b);
    chk(b == 8'hC3, "R2 R7 queued byte sent after enabling", b, 8'hC3);

    // R5 R3: mode 0, code 1 -> 8 high halves of 2 cycles
    wtx(8'hA5);
    count_high(n);
    chk(n == 16, "R3 code1 high time", n, 16);
    wait_idle(); rrx(b);
    chk(b == 8'hA5, "R5 R7 mode0 loopback", b, 8'hA5);

    // R3 code 0 clamps to 1
    wcfg(mk(1, 0, 0, 3'd0, 4'hF, 1));
    wtx(8'h5A);
    count_high(n);
    chk(n == 16, "R3 code0 clamped", n, 16);
    wait_idle(); rrx(b);
    chk(b == 8'h5A, "R7 loopback code0", b, 8'h5A);

    // R3 code 3
    wcfg(mk(1, 0, 0, 3'd3, 4'hF, 1));
    wtx(8'h81);
    count_high(n);
    chk(n == 64, "R3 code3 high time", n, 64);
    wait_idle(); rrx(b);
    chk(b == 8'h81, "R7 loopback code3", b, 8'h81);

    // R6 R4: mode 3, code 2
    wcfg(mk(1, 1, 1, 3'd2, 4'hF, 1));
    @(negedge clk);
    chk(sclk == 1, "R4 idle high with polarity set", sclk, 1);
    wtx(8'h3C);
    wait_idle();
    chk(sclk == 1, "R4 back to idle high", sclk, 1);
    rrx(b);
    chk(b == 8'h3C, "R6 R7 mode3 loopback", b, 8'h3C);

    // R6 with random miso, mode 1; model checks every cycle
    lb = 0;
    wcfg(mk(1, 0, 1, 3'd1, 4'hF, 1));
    wtx(8'h96); wtx(8'h0F);
    wait_idle();
    rrx(b); rrx(b);
    wcfg(mk(1, 1, 0, 3'd1, 4'hF, 1));
    wtx(8'hE7);
    wait_idle(); rrx(b);
    lb = 1;

    // R9: overflow and rx-full stall
    ctrl_en = 0;
    wtx(8'h11); wtx(8'h22); wtx(8'h33); wtx(8'h44);
    chk(tx_full, "R9 tx full at depth", tx_full, 1);
    wtx(8'h55);
    ctrl_en = 1;
    wait_idle();
    chk(!rx_empty, "R9 rx filled", rx_empty, 0);
    wtx(8'h66);
    repeat (30) @(negedge clk);
    chk(!busy, "R9 no start while rx full", busy, 0);
    rrx(b); chk(b == 8'h11, "R9 first", b, 8'h11);
    rrx(b); chk(b == 8'h22, "R9 second", b, 8'h22);
    rrx(b); chk(b == 8'h33, "R9 third", b, 8'h33);
    rrx(b); chk(b == 8'h44, "R9 fourth (fifth write dropped)", b, 8'h44);
    wait_idle();
    rrx(b); chk(b == 8'h66, "R9 stalled byte after drain", b, 8'h66);
    chk(rx_empty, "R9 queue empty", rx_empty, 1);
    rrx(b);
    chk(rx_empty, "R9 read of empty queue ignored", rx_empty, 1);
    wtx(8'h7E); wait_idle(); rrx(b);
    chk(b == 8'h7E, "R9 pointers intact after empty read", b, 8'h7E);

    // R8 select lines
    wcfg(mk(1, 0, 0, 3'd1, 4'b1101, 1));
    chk(ss_n == 4'b1101, "R8 manual one-hot", ss_n, 4'b1101);
    wcfg(mk(1, 0, 0, 3'd1, 4'b0010, 1));
    chk(ss_n == 4'b0010, "R8 manual binary code", ss_n, 4'b0010);
    wcfg(mk(1, 0, 0, 3'd1, 4'b1110, 0));
    chk(ss_n == 4'hF, "R8 auto idle deselect", ss_n, 4'hF);
    wtx(8'h42);
    while (!busy) @(negedge clk);
    chk(ss_n == 4'b1110, "R8 auto during byte", ss_n, 4'b1110);
    wait_idle();
    chk(ss_n == 4'hF, "R8 auto after byte", ss_n, 4'hF);
    rrx(b);

    // R10 setup write mid-byte does not change the running byte
    wcfg(mk(1, 0, 0, 3'd2, 4'hF, 1));
    wtx(8'hB4);
    while (!busy) @(negedge clk);
    repeat (10) @(negedge clk);
    wcfg(mk(1, 1, 1, 3'd1, 4'hF, 1));
    chk(busy, "R10 busy held mid-byte", busy, 1);
    wait_idle(); rrx(b);
    chk(b == 8'hB4, "R10 latched mode byte", b, 8'hB4);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule